// File: doc/BRIEF.md
# Octal Bus Transceiver with Odd-Parity Guard

This block joins two 8-bit buses, an A side and a B side, and moves data between them in a direction chosen by two active-low output enables. Each side offers a separate input vector, output vector and output-enable, so the tri-state pads live outside the module. Data travelling from A to B carries a generated odd-parity bit. Data arriving on B is checked, together with the incoming parity bit, whenever the A side is being driven.

A parity failure is not reported immediately. It is captured on a rising clock edge into a sticky flag register. The flag stays set until an active-low asynchronous clear releases it. The clear asserts at once and is released through a short synchronizer. When both enables are low, the block drives A data onto B with the parity bit inverted. This produces a known error, so system software can prove the checking path works. The error flag is presented as a drive-low enable, suited to a wired open-drain line, and as a registered level.

Top module: `bus_xcvr_parity`

## Requirements
- R1: With `oe_a_n` low, `a_oe` is 1 and `a_out` equals `b_in`. With `oe_a_n` high, `a_oe` is 0 and `a_out` reads all zeros.
- R2: With `oe_b_n` low, `b_oe` is 1 and `b_out` equals `a_in`. With `oe_b_n` high, `b_oe` is 0 and `b_out` reads all zeros.
- R3: With `oe_b_n` low and `oe_a_n` high, `par_oe` is 1 and `par_out` makes the XOR of `a_in` and `par_out` equal 1 (odd). With `oe_b_n` high, `par_oe` is 0 and `par_out` is 0.
- R4: With both enables low, `par_out` is the inverse of the odd-parity bit, so the XOR of `a_in` and `par_out` is 0. Through the pad readback this produces an error capture.
- R5: With `oe_a_n` low, an even XOR over `b_in` and `par_in` is an error. At the next rising edge it sets `err_flag` to 1, provided the clear is fully released.
- R6: With `oe_a_n` high, no check takes place, and a clock edge leaves a clear flag at 0 whatever `b_in` and `par_in` hold.
- R7: Once set, `err_flag` stays 1 across later edges that carry no error, until a clear.
- R8: A low `clr_n` forces `err_flag` to 0 immediately, without a clock edge. While it stays low, an edge carrying an error does not set the flag.
- R9: After `clr_n` rises, the first two rising edges cannot set the flag (synchronizer depth 2). The third edge can.
- R10: `err_drive_low` equals `err_flag` at all times; a high value means the shared error line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for the error flag |
| clr_n | input | 1 | Active-low asynchronous clear of the error flag |
| oe_a_n | input | 1 | Active-low enable of the A-side outputs (B to A) |
| oe_b_n | input | 1 | Active-low enable of the B-side and parity outputs (A to B) |
| a_in | input | 8 | A-side pad input |
| a_out | output | 8 | A-side pad output data |
| a_oe | output | 1 | A-side pad drive enable |
| b_in | input | 8 | B-side pad input |
| b_out | output | 8 | B-side pad output data |
| b_oe | output | 1 | B-side pad drive enable |
| par_in | input | 1 | Parity pad input |
| par_out | output | 1 | Parity pad output data |
| par_oe | output | 1 | Parity pad drive enable |
| err_drive_low | output | 1 | 1 pulls the open-drain error line low |
| err_flag | output | 1 | Registered error level, 1 when an error is stored |

## Verification
Two situations are hard to reach from the ports. The first is the diagnostic error: it only appears when the bench models the pads, so that `b_in` and `par_in` read back what the block itself drives. The bench wires that readback continuously and then enables both directions. The second is the blind window after a clear. An error is presented on the very edges that follow the release of `clr_n`, and the flag is expected to stay low for exactly two edges. Random mode, data and external-driver values then run alongside occasional clears, all against a bench-side reference of the flag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // bit0 = A side driven, bit1 = B side driven
  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'b00,
    MODE_B2A     = 2'b01,
    MODE_A2B     = 2'b10,
    MODE_DIAG    = 2'b11
  } xfer_mode_e;

  function automatic xfer_mode_e decode_mode(input logic oe_a_n, input logic oe_b_n);
    return xfer_mode_e'({~oe_b_n, ~oe_a_n});
  endfunction

endpackage

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  xfer_mode_e       mode,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  logic a_en;
  logic b_en;

  always_comb begin
    a_en = mode[0];
    b_en = mode[1];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    always_comb begin
      a_out[i] = a_en & b_in[i];
      b_out[i] = b_en & a_in[i];
    end
  end

  always_comb begin
    a_oe = a_en;
    b_oe = b_en;
  end

  p_a_path_r1: assert property (@(posedge clk) disable iff (!clr_n)
    a_oe |-> (a_out == b_in));
  p_a_idle_r1: assert property (@(posedge clk) disable iff (!clr_n)
    !a_oe |-> (a_out == '0));
  p_b_path_r2: assert property (@(posedge clk) disable iff (!clr_n)
    b_oe |-> (b_out == a_in));
  p_b_idle_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !b_oe |-> (b_out == '0));

endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  xfer_mode_e       mode,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             par_in,
  output logic             par_out,
  output logic             par_oe,
  output logic             err_cond
);

  logic odd_bit;
  logic rx_xor;

  // generator: bit that makes data plus parity odd
  always_comb begin
    odd_bit = ~(^a_in);
    unique case (mode)
      MODE_A2B:  par_out = odd_bit;
      MODE_DIAG: par_out = ~odd_bit;
      default:   par_out = 1'b0;
    endcase
    par_oe = mode[1];
  end

  // checker: active while A side is driven
  always_comb begin
    rx_xor   = (^b_in) ^ par_in;
    err_cond = mode[0] & ~rx_xor;
  end

  p_par_gen_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_A2B) |-> ((^{a_in, par_out}) == 1'b1));
  p_par_off_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !mode[1] |-> (!par_oe && !par_out));
  p_par_diag_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_DIAG) |-> ((^{a_in, par_out}) == 1'b0));
  p_no_check_r6: assert property (@(posedge clk) disable iff (!clr_n)
    !mode[0] |-> !err_cond);

endmodule

// File: rtl/xcvr_err_flag.sv
module xcvr_err_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic err_cond,
  output logic err_flag,
  output logic capture_ok
);

  localparam int STG = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [STG-1:0] sync_q;
  logic [STG-1:0] sync_nxt;
  logic           flag_q;
  logic           flag_nxt;
  logic           flag_en;

  // clear release synchronizer: asserts at once, releases after STG edges
  if (STG == 1) begin : g_sync_one
    always_comb sync_nxt = 1'b1;
  end else begin : g_sync_chain
    always_comb sync_nxt = {sync_q[STG-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  always_comb capture_ok = sync_q[STG-1];

  // sticky flag: enable only on error, next state always set
  always_comb begin
    flag_en  = err_cond;
    flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge capture_ok) begin
    if (!capture_ok)  flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_nxt;
  end

  always_comb err_flag = flag_q;

  p_set_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (capture_ok && err_cond) |=> err_flag);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!clr_n)
    err_flag |=> err_flag);
  p_blind_r9: assert property (@(posedge clk) disable iff (!clr_n)
    !capture_ok |-> !err_flag);

endmodule

// File: rtl/bus_xcvr_parity.sv
module bus_xcvr_parity
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             par_in,
  output logic             par_out,
  output logic             par_oe,
  output logic             err_drive_low,
  output logic             err_flag
);

  xfer_mode_e mode;
  logic       err_cond;
  logic       flag_q;
  logic       capture_ok;

  always_comb mode = decode_mode(oe_a_n, oe_b_n);

  xcvr_route #(.WIDTH(WIDTH)) u_route (
    .clk   (clk),
    .clr_n (clr_n),
    .mode  (mode),
    .a_in  (a_in),
    .b_in  (b_in),
    .a_out (a_out),
    .a_oe  (a_oe),
    .b_out (b_out),
    .b_oe  (b_oe)
  );

  xcvr_parity #(.WIDTH(WIDTH)) u_parity (
    .clk      (clk),
    .clr_n    (clr_n),
    .mode     (mode),
    .a_in     (a_in),
    .b_in     (b_in),
    .par_in   (par_in),
    .par_out  (par_out),
    .par_oe   (par_oe),
    .err_cond (err_cond)
  );

  xcvr_err_flag #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
    .clk        (clk),
    .clr_n      (clr_n),
    .err_cond   (err_cond),
    .err_flag   (flag_q),
    .capture_ok (capture_ok)
  );

  always_comb begin
    err_flag      = flag_q;
    err_drive_low = flag_q;
  end

  p_noset_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n && !err_flag) |=> !err_flag);
  p_drive_r10: assert property (@(posedge clk) disable iff (!clr_n)
    err_drive_low == err_flag);

endmodule

// File: tb/bus_xcvr_parity_bench.sv
module bus_xcvr_parity_bench;

  localparam int W = 8;

  logic         clk;
  logic         clr_n;
  logic         oe_a_n;
  logic         oe_b_n;
  logic [W-1:0] a_in;
  logic [W-1:0] b_ext;
  logic         par_ext;
  logic [W-1:0] a_out;
  logic         a_oe;
  logic [W-1:0] b_out;
  logic         b_oe;
  logic         par_out;
  logic         par_oe;
  logic         err_drive_low;
  logic         err_flag;
  logic [W-1:0] b_in;
  logic         par_in;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_flag = 1'b0;
  int rel_cnt = 0;

  // pad model: a driven pad reads back its own value
  assign b_in   = b_oe   ? b_out   : b_ext;
  assign par_in = par_oe ? par_out : par_ext;

  bus_xcvr_parity u_bus_xcvr_parity (
    .clk(clk), .clr_n(clr_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .err_drive_low(err_drive_low), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic f_par(input logic oa, input logic ob, input logic [W-1:0] a);
    if (ob)      return 1'b0;
    else if (!oa) return ^a;
    else          return ~(^a);
  endfunction

  function automatic logic f_err(input logic oa, input logic ob,
                                 input logic [W-1:0] a, input logic [W-1:0] bx, input logic px);
    logic [W-1:0] bp;
    logic pp;
    bp = ob ? bx : a;
    pp = ob ? px : f_par(oa, ob, a);
    return !oa && ((^bp ^ pp) == 1'b0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input string freq, input logic oa, input logic ob,
                      input logic [W-1:0] a, input logic [W-1:0] bx, input logic px);
    logic [W-1:0] bp;
    logic cond;
    oe_a_n = oa; oe_b_n = ob; a_in = a; b_ext = bx; par_ext = px;
    #2;
    bp = ob ? bx : a;
    chk("R1 a_oe",   32'(a_oe),    32'(!oa));
    chk("R1 a_out",  32'(a_out),   oa ? 32'd0 : 32'(bp));
    chk("R2 b_oe",   32'(b_oe),    32'(!ob));
    chk("R2 b_out",  32'(b_out),   ob ? 32'd0 : 32'(a));
    chk("R3 par_oe", 32'(par_oe),  32'(!ob));
    chk("R3/R4 par_out", 32'(par_out), 32'(f_par(oa, ob, a)));
    cond = f_err(oa, ob, a, bx, px);
    @(posedge clk);
    if (clr_n) begin
      if (rel_cnt >= 2 && cond) m_flag = 1'b1;
      if (rel_cnt < 2) rel_cnt++;
    end
    @(negedge clk);
    chk(freq, 32'(err_flag), 32'(m_flag));
    chk("R10 drive", 32'(err_drive_low), 32'(err_flag));
  endtask

  // clear with an error present across one edge
  task automatic do_clear();
    oe_a_n = 1'b0; oe_b_n = 1'b1; b_ext = 8'h00; par_ext = 1'b0;
    clr_n = 1'b0;
    #2;
    m_flag = 1'b0; rel_cnt = 0;
    chk("R8 async clear", 32'(err_flag), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 clear beats edge", 32'(err_flag), 32'd0);
    clr_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    clr_n = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b1;
    a_in = '0; b_ext = '0; par_ext = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset flag", 32'(err_flag), 32'd0);
    chk("R10 reset drive", 32'(err_drive_low), 32'd0);
    clr_n = 1'b1;

    // R9: error right after release; blind for two edges
    step("R9 edge1", 1'b0, 1'b1, 8'h00, 8'h03, 1'b0);
    step("R9 edge2", 1'b0, 1'b1, 8'h00, 8'h03, 1'b0);
    step("R5 edge3 sets", 1'b0, 1'b1, 8'h00, 8'h03, 1'b0);
    // R7: no error, flag holds
    step("R7 sticky", 1'b0, 1'b1, 8'h00, 8'h01, 1'b0);
    step("R7 sticky iso", 1'b1, 1'b1, 8'h55, 8'h00, 1'b0);
    do_clear();
    step("R9 post-clear", 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
    step("R9 post-clear", 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
    // R6: bad parity on pads but A not driven
    step("R6 no check", 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
    step("R6 no check a2b", 1'b1, 1'b0, 8'hF0, 8'h00, 1'b0);
    // good parity received, no set
    step("R5 good parity", 1'b0, 1'b1, 8'h00, 8'h07, 1'b0);
    step("R5 good parity", 1'b0, 1'b1, 8'hAA, 8'h00, 1'b1);
    // R4: diagnostic mode forces an error
    step("R4 diag sets", 1'b0, 1'b0, 8'h5A, 8'hFF, 1'b1);
    step("R7 holds", 1'b1, 1'b0, 8'h01, 8'h00, 1'b0);
    do_clear();
    step("R9 edge1", 1'b0, 1'b0, 8'h81, 8'h00, 1'b0);
    step("R9 edge2", 1'b0, 1'b0, 8'h81, 8'h00, 1'b0);
    step("R4 diag edge3", 1'b0, 1'b0, 8'h81, 8'h00, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      if (r == 4'd0) do_clear();
      else step("R5/R7 random flag", 1'($urandom), 1'($urandom),
                8'($urandom), 8'($urandom), 1'($urandom));
    end
    summary();
  end

endmodule